// File: doc/BRIEF.md
# Mixed-Length Instruction Pattern Decoder

This block turns a stream of 16-bit halfwords into decoded instructions whose encodings are either one or two halfwords long. Each accepted halfword is first compared against a small table of short patterns. A pattern is a mask of fixed bits plus the values those bits must hold. If a short pattern hits, the instruction is decoded from that halfword alone.

If no short pattern hits, the halfword is kept as the low half of a long instruction. The next accepted halfword becomes the high half, and the 32-bit word is compared against the long patterns. Register numbers in the long add encoding are split: the low three bits sit in the low half and the high three bits in the high half. The decoder joins them back into 6-bit numbers. Immediates are sign-extended to the data width.

The result leaves on a one-cycle `dec_valid` pulse, one clock after the final halfword is accepted. When a long word matches no pattern, the pulse comes with `dec_illegal` set and every field cleared.

Top module: `vld_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dec_valid` is 0 and no low half is pending.
- R2: A halfword whose bits [3:0] are 0000 is a short branch. One cycle after acceptance the block gives `dec_op`=1, `dec_len32`=0, `dec_cond`=bits[7:4] and `dec_imm` = bits[15:8] sign-extended.
- R3: A halfword whose bits [4:0] are 00100 is a short load, `dec_op`=2. It gives `dec_rd`=bits[15:13], `dec_rn`=bits[12:10], `dec_imm` = bits[9:7] sign-extended and `dec_size`=bits[6:5]. The register numbers are zero-extended to 6 bits, and `dec_rm`=0.
- R4: A halfword whose bits [4:0] are 10100 is a short store, `dec_op`=3. Its fields are laid out as in R3.
- R5: A halfword that matches no short pattern produces no output. It is kept, and the next accepted halfword supplies bits [31:16] of a long word.
- R6: A long word whose bits [3:0] are 1000 is a long branch: `dec_op`=1, `dec_len32`=1, `dec_cond`=bits[7:4] and `dec_imm` = bits[31:8] sign-extended.
- R7: A long word whose bits [22:16] are 0001010 and bits [6:0] are 0011111 is an add, `dec_op`=4, `dec_len32`=1. It gives `dec_rd`={bits[31:29],bits[15:13]}, `dec_rn`={bits[28:26],bits[12:10]} and `dec_rm`={bits[25:23],bits[9:7]}.
- R8: A long word that matches no long pattern gives `dec_valid` with `dec_illegal`=1, `dec_len32`=1, `dec_op`=0 and all fields zero.
- R9: `hw_ready` is always 1. Cycles with `hw_valid` low have no effect, including cycles between the two halves of a long instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Halfword present |
| hw_ready | output | 1 | Halfword accepted (always 1) |
| hw_data | input | 16 | Halfword |
| dec_valid | output | 1 | Decoded instruction pulse |
| dec_illegal | output | 1 | No pattern matched |
| dec_len32 | output | 1 | Instruction was two halfwords |
| dec_op | output | 3 | Class: 0 none, 1 branch, 2 load, 3 store, 4 add |
| dec_rd | output | 6 | Destination register |
| dec_rn | output | 6 | First source register |
| dec_rm | output | 6 | Second source register |
| dec_imm | output | DATA_W | Sign-extended immediate |
| dec_cond | output | 4 | Branch condition |
| dec_size | output | 2 | Load/store access size |

## Verification
The properties assume that `hw_valid` is never X after reset. They also assume that every output pulse follows an accepted halfword. Halfword alignment is taken for granted: the first halfword after reset always starts an instruction.

The stimulus keeps to these assumptions. It drives inputs only at falling edges and starts from an idle bus. It always completes a long instruction with a second halfword before it starts a new one. Idle gaps are inserted only between whole instructions or between the two halves of one.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int HW_W  = 16;
    localparam int IW_W  = 32;
    localparam int RW    = 6;
    localparam int OPW   = 3;

    localparam logic [OPW-1:0] OP_NONE = 3'd0;
    localparam logic [OPW-1:0] OP_BR   = 3'd1;
    localparam logic [OPW-1:0] OP_LD   = 3'd2;
    localparam logic [OPW-1:0] OP_ST   = 3'd3;
    localparam logic [OPW-1:0] OP_ADD  = 3'd4;

    // short table, entry 0 in the low slice; lower index wins
    localparam int N16 = 3;
    localparam logic [N16*HW_W-1:0] P16_MASK = {16'h001F, 16'h001F, 16'h000F};
    localparam logic [N16*HW_W-1:0] P16_BITS = {16'h0014, 16'h0004, 16'h0000};
    localparam logic [N16*OPW-1:0]  P16_OP   = {OP_ST, OP_LD, OP_BR};

    // long table
    localparam int N32 = 2;
    localparam logic [N32*IW_W-1:0] P32_MASK = {32'h007F_007F, 32'h0000_000F};
    localparam logic [N32*IW_W-1:0] P32_BITS = {32'h000A_001F, 32'h0000_0008};
    localparam logic [N32*OPW-1:0]  P32_OP   = {OP_ADD, OP_BR};

endpackage

// File: rtl/vld_match.sv
module vld_match #(
    parameter int              W     = 16,
    parameter int              N     = 1,
    parameter logic [N*W-1:0]  MASKS = '0,
    parameter logic [N*W-1:0]  BITS  = '0
) (
    input  logic [W-1:0] word,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        assign hit[g] = ((word & MASKS[g*W +: W]) == BITS[g*W +: W]);
    end
endmodule

// File: rtl/vld_pick.sv
module vld_pick
    import vld_pkg::*;
#(
    parameter int                N   = 1,
    parameter logic [N*OPW-1:0]  OPS = '0
) (
    input  logic [N-1:0]   hit,
    output logic [OPW-1:0] op
);
    always_comb begin
        op = OP_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) op = OPS[i*OPW +: OPW];
        end
    end
endmodule

// File: rtl/vld_fields.sv
module vld_fields
    import vld_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IW_W-1:0]   word,
    input  logic              is32,
    input  logic [OPW-1:0]    op,
    output logic [RW-1:0]     rd,
    output logic [RW-1:0]     rn,
    output logic [RW-1:0]     rm,
    output logic [DATA_W-1:0] imm,
    output logic [3:0]        cond,
    output logic [1:0]        size
);
    localparam int PAD24 = DATA_W - 24;
    localparam int PAD8  = DATA_W - 8;
    localparam int PAD3  = DATA_W - 3;

    always_comb begin
        rd   = '0;
        rn   = '0;
        rm   = '0;
        imm  = '0;
        cond = '0;
        size = '0;
        case (op)
            OP_BR: begin
                cond = word[7:4];
                if (is32) imm = {{PAD24{word[31]}}, word[31:8]};
                else      imm = {{PAD8{word[15]}}, word[15:8]};
            end
            OP_LD, OP_ST: begin
                rd   = {3'b000, word[15:13]};
                rn   = {3'b000, word[12:10]};
                imm  = {{PAD3{word[9]}}, word[9:7]};
                size = word[6:5];
            end
            OP_ADD: begin
                rd = {word[31:29], word[15:13]};
                rn = {word[28:26], word[12:10]};
                rm = {word[25:23], word[9:7]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
    import vld_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_valid,
    output logic              hw_ready,
    input  logic [15:0]       hw_data,
    output logic              dec_valid,
    output logic              dec_illegal,
    output logic              dec_len32,
    output logic [2:0]        dec_op,
    output logic [5:0]        dec_rd,
    output logic [5:0]        dec_rn,
    output logic [5:0]        dec_rm,
    output logic [DATA_W-1:0] dec_imm,
    output logic [3:0]        dec_cond,
    output logic [1:0]        dec_size
);
    typedef struct packed {
        logic              pend;
        logic [HW_W-1:0]   lo;
        logic              vld;
        logic              ill;
        logic              l32;
        logic [OPW-1:0]    op;
        logic [RW-1:0]     rd;
        logic [RW-1:0]     rn;
        logic [RW-1:0]     rm;
        logic [DATA_W-1:0] imm;
        logic [3:0]        cond;
        logic [1:0]        size;
    } state_t;

    state_t st_d, st_q;

    logic [N16-1:0]    hit16;
    logic [N32-1:0]    hit32;
    logic [OPW-1:0]    op16, op32, fop;
    logic [IW_W-1:0]   word32, fword;
    logic [RW-1:0]     f_rd, f_rn, f_rm;
    logic [DATA_W-1:0] f_imm;
    logic [3:0]        f_cond;
    logic [1:0]        f_size;

    assign word32 = {hw_data, st_q.lo};

    vld_match #(.W(HW_W), .N(N16), .MASKS(P16_MASK), .BITS(P16_BITS)) i_m16 (
        .word(hw_data), .hit(hit16));
    vld_match #(.W(IW_W), .N(N32), .MASKS(P32_MASK), .BITS(P32_BITS)) i_m32 (
        .word(word32), .hit(hit32));

    vld_pick #(.N(N16), .OPS(P16_OP)) i_p16 (.hit(hit16), .op(op16));
    vld_pick #(.N(N32), .OPS(P32_OP)) i_p32 (.hit(hit32), .op(op32));

    assign fword = st_q.pend ? word32 : {16'h0000, hw_data};
    assign fop   = st_q.pend ? op32   : op16;

    vld_fields #(.DATA_W(DATA_W)) i_fld (
        .word(fword), .is32(st_q.pend), .op(fop),
        .rd(f_rd), .rn(f_rn), .rm(f_rm), .imm(f_imm),
        .cond(f_cond), .size(f_size));

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (hw_valid) begin
            if (!st_q.pend && (op16 == OP_NONE)) begin
                st_d.pend = 1'b1;
                st_d.lo   = hw_data;
            end else begin
                st_d.pend = 1'b0;
                st_d.vld  = 1'b1;
                st_d.l32  = st_q.pend;
                st_d.op   = fop;
                st_d.ill  = (fop == OP_NONE);
                st_d.rd   = f_rd;
                st_d.rn   = f_rn;
                st_d.rm   = f_rm;
                st_d.imm  = f_imm;
                st_d.cond = f_cond;
                st_d.size = f_size;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hw_ready    = 1'b1;
    assign dec_valid   = st_q.vld;
    assign dec_illegal = st_q.ill;
    assign dec_len32   = st_q.l32;
    assign dec_op      = st_q.op;
    assign dec_rd      = st_q.rd;
    assign dec_rn      = st_q.rn;
    assign dec_rm      = st_q.rm;
    assign dec_imm     = st_q.imm;
    assign dec_cond    = st_q.cond;
    assign dec_size    = st_q.size;
endmodule

// File: rtl/vld_decoder_chk.sv
module vld_decoder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_valid,
    input logic              hw_ready,
    input logic [15:0]       hw_data,
    input logic              dec_valid,
    input logic              dec_illegal,
    input logic              dec_len32,
    input logic [2:0]        dec_op,
    input logic [5:0]        dec_rd,
    input logic [5:0]        dec_rn,
    input logic [5:0]        dec_rm,
    input logic [DATA_W-1:0] dec_imm,
    input logic [3:0]        dec_cond,
    input logic [1:0]        dec_size
);
    a_r2_short_branch_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_op == 3'd1 && !dec_len32) |->
            (dec_imm[DATA_W-1:7] == '0 || dec_imm[DATA_W-1:7] == '1));

    a_r3_ldst_short_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_op == 3'd2 || dec_op == 3'd3)) |->
            (!dec_len32 && dec_rd[5:3] == 3'd0 && dec_rn[5:3] == 3'd0 && dec_rm == 6'd0));

    a_r5_output_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(hw_valid));

    a_r6_long_branch_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_op == 3'd1 && dec_len32) |->
            (dec_imm[DATA_W-1:23] == '0 || dec_imm[DATA_W-1:23] == '1));

    a_r7_add_is_long: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_op == 3'd4) |-> (dec_len32 && !dec_illegal));

    a_r8_illegal_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_illegal) |->
            (dec_len32 && dec_op == 3'd0 && dec_rd == 6'd0 && dec_rn == 6'd0 &&
             dec_rm == 6'd0 && dec_imm == '0 && dec_cond == 4'd0 && dec_size == 2'd0));

    a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid |-> hw_ready);
endmodule

bind vld_decoder vld_decoder_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_data(hw_data), .dec_valid(dec_valid), .dec_illegal(dec_illegal),
    .dec_len32(dec_len32), .dec_op(dec_op), .dec_rd(dec_rd), .dec_rn(dec_rn),
    .dec_rm(dec_rm), .dec_imm(dec_imm), .dec_cond(dec_cond), .dec_size(dec_size));

// File: tb/test_vld_decoder.sv
`timescale 1ns/1ps
module test_vld_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_valid = 1'b0;
    logic        hw_ready;
    logic [15:0] hw_data = '0;
    logic        dec_valid, dec_illegal, dec_len32;
    logic [2:0]  dec_op;
    logic [5:0]  dec_rd, dec_rn, dec_rm;
    logic [31:0] dec_imm;
    logic [3:0]  dec_cond;
    logic [1:0]  dec_size;

    always #4 clk = ~clk;

    vld_decoder #(.DATA_W(32)) i_vld_decoder (
        .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
        .hw_data(hw_data), .dec_valid(dec_valid), .dec_illegal(dec_illegal),
        .dec_len32(dec_len32), .dec_op(dec_op), .dec_rd(dec_rd), .dec_rn(dec_rn),
        .dec_rm(dec_rm), .dec_imm(dec_imm), .dec_cond(dec_cond), .dec_size(dec_size));

    typedef struct packed {
        logic        ill;
        logic        l32;
        logic [2:0]  op;
        logic [5:0]  rd;
        logic [5:0]  rn;
        logic [5:0]  rm;
        logic [31:0] imm;
        logic [3:0]  cond;
        logic [1:0]  size;
    } exp_t;

    typedef struct packed {
        exp_t      e;
        logic [7:0] tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: compare every output pulse against the scoreboard
    always @(negedge clk) begin
        if (mon_on && dec_valid) begin
            exp_t a;
            a = '{dec_illegal, dec_len32, dec_op, dec_rd, dec_rn, dec_rm,
                  dec_imm, dec_cond, dec_size};
            if (q.size() == 0) begin
                check(1'b0, "R5/R9", "unexpected output", {3'b0, a}, 64'd0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(a == it.e, $sformatf("R%0d", it.tag), "decode",
                      {3'b0, a}, {3'b0, it.e});
            end
        end
    end

    task automatic put(input logic [15:0] hw);
        @(negedge clk);
        hw_valid = 1'b1;
        hw_data  = hw;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hw_valid = 1'b0;
            hw_data  = 16'hFFFF;
        end
    endtask

    function automatic exp_t blank();
        return '0;
    endfunction

    // R2 short branch
    task automatic send_br16(input logic [7:0] im, input logic [3:0] c);
        exp_t e = blank();
        e.op = 3'd1; e.cond = c; e.imm = {{24{im[7]}}, im};
        put({im, c, 4'b0000});
        q.push_back('{e, 8'd2});
    endtask

    // R3 load / R4 store
    task automatic send_ldst(input bit st, input logic [2:0] d, input logic [2:0] n,
                             input logic [2:0] im, input logic [1:0] sz);
        exp_t e = blank();
        e.op = st ? 3'd3 : 3'd2;
        e.rd = {3'b0, d}; e.rn = {3'b0, n};
        e.imm = {{29{im[2]}}, im}; e.size = sz;
        put({d, n, im, sz, st, 4'b0100});
        q.push_back('{e, st ? 8'd4 : 8'd3});
    endtask

    // two halves with optional gap; R5 checked while the low half is pending
    task automatic send_long(input logic [15:0] lo, input logic [15:0] hi,
                             input exp_t e, input logic [7:0] tag, input int gap);
        put(lo);
        if (gap > 0) begin
            idle(gap);
        end else begin
            @(negedge clk);
        end
        check(dec_valid == 1'b0, "R5", "no output on first half",
              {63'd0, dec_valid}, 64'd0);
        hw_valid = 1'b1;
        hw_data  = hi;
        q.push_back('{e, tag});
    endtask

    task automatic send_br32(input logic [23:0] im, input logic [3:0] c, input int gap);
        exp_t e = blank();
        e.op = 3'd1; e.l32 = 1'b1; e.cond = c; e.imm = {{8{im[23]}}, im};
        send_long({im[7:0], c, 4'b1000}, im[23:8], e, 8'd6, gap);
    endtask

    task automatic send_add(input logic [5:0] d, input logic [5:0] n,
                            input logic [5:0] m, input int gap);
        exp_t e = blank();
        e.op = 3'd4; e.l32 = 1'b1; e.rd = d; e.rn = n; e.rm = m;
        send_long({d[2:0], n[2:0], m[2:0], 7'b0011111},
                  {d[5:3], n[5:3], m[5:3], 3'b000, 4'b1010}, e, 8'd7, gap);
    endtask

    task automatic send_bad(input logic [15:0] lo, input logic [15:0] hi, input int gap);
        exp_t e = blank();
        e.ill = 1'b1; e.l32 = 1'b1;
        send_long(lo, hi, e, 8'd8, gap);
    endtask

    task automatic drain();
        idle(3);
        check(q.size() == 0, "R5", "scoreboard drained", 64'(q.size()), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R1", "valid in reset", {63'd0, dec_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0, "R1", "valid after reset", {63'd0, dec_valid}, 64'd0);
        check(hw_ready == 1'b1, "R9", "ready high", {63'd0, hw_ready}, 64'd1);
        mon_on = 1'b1;

        // R1: nothing pending, so a short branch decodes at once
        send_br16(8'h05, 4'h3);
        send_br16(8'hF0, 4'hC);
        send_ldst(1'b0, 3'd7, 3'd2, 3'b101, 2'd3);
        send_ldst(1'b0, 3'd1, 3'd6, 3'b011, 2'd1);
        send_ldst(1'b1, 3'd4, 3'd5, 3'b100, 2'd2);
        send_br32(24'h000123, 4'h1, 0);
        send_br32(24'h800001, 4'hE, 0);
        send_add(6'd63, 6'd0, 6'd42, 0);
        send_add(6'd17, 6'd33, 6'd9, 3);     // R9 gap between halves
        send_bad(16'h001F, 16'h0000, 0);
        send_bad(16'h0002, 16'hFFFF, 2);
        idle(2);                              // R9 idle cycles
        send_br16(8'h7F, 4'h0);
        drain();

        for (int k = 0; k < 40; k++) begin
            int kind = $urandom_range(0, 5);
            int gap  = $urandom_range(0, 2);
            case (kind)
                0: send_br16(8'($urandom), 4'($urandom));
                1: send_ldst(1'b0, 3'($urandom), 3'($urandom), 3'($urandom), 2'($urandom));
                2: send_ldst(1'b1, 3'($urandom), 3'($urandom), 3'($urandom), 2'($urandom));
                3: send_br32(24'($urandom), 4'($urandom), gap);
                4: send_add(6'($urandom), 6'($urandom), 6'($urandom), gap);
                default: send_bad(16'h0006, 16'($urandom), gap);
            endcase
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        drain();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule